// File: doc/BRIEF.md
# Saturating Dual-Accumulator Multiply Unit

This block multiplies two 16-bit operand halves and folds the product into one of two 40-bit accumulators. Each accumulator is a 32-bit low word under an 8-bit sign extension. Per operation, the caller picks the accumulator, whether the product replaces, adds to or subtracts from it, and one of six arithmetic modes. A mode fixes three things: how each operand is interpreted, whether the accumulator is clamped to a signed or an unsigned 32-bit range, and how a 16-bit half is pulled out of the result.

The updated accumulator can also be written to a destination register. The write can cover the full 32 bits or only the upper or lower half. In a half write, the untouched half comes from the register's current value, which the caller supplies on `reg_in_i`.

Three separate saturation points exist: the product, the accumulator and the extracted half. Each one feeds its own overflow flags. Every accumulator has a live overflow flag and a sticky overflow flag. The register result has a live flag, a copy of the live flag, and a sticky flag. An accepted operation updates all state on a single clock edge.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset, both accumulators, the result register and all seven overflow flags read zero.
- R2: In signed fractional mode (mode 0), the product is a×b doubled. When both operands are 0x8000, the product is forced to 0x7FFFFFFF and the selected accumulator's live and sticky overflow flags are set. This happens even if the accumulator result stays in range: 0x0010000000 minus this product gives 0xFF90000001.
- R3: In signed modes (0, 3, 5), the accumulator result is clamped to the signed 32-bit range. Positive overflow gives 0x007FFFFFFF and negative overflow gives 0xFF80000000.
- R4: In unsigned modes (1, 2, 4), the accumulator result is clamped to the range 0 to 0x00FFFFFFFF. A result below zero becomes 0.
- R5: Each operation sets the selected accumulator's live overflow flag to (product saturated OR accumulator clamped). It ORs the same value into that accumulator's sticky flag, and no operation ever clears a sticky flag.
- R6: Selector 0 chooses accumulator A0 and selector 1 chooses A1. An operation leaves the other accumulator and both of its overflow flags unchanged.
- R7: Operation code 0 assigns the product, code 1 adds it, code 2 subtracts it, and code 3 acts as add.
- R8: Destination code 0 writes nothing. Code 1 writes the accumulator's low 32 bits. Code 2 writes the extracted half into bits 31:16 and code 3 writes it into bits 15:0, and in both cases the other half is taken from reg_in_i.
- R9: The extracted half depends on the mode. Modes 0 and 4 take bits 31:16 without rounding. Mode 1 adds 0x8000 first and saturates to 0xFFFF. Mode 2 saturates the unsigned value to 0xFFFF. Modes 3 and 5 saturate the signed value to 0x7FFF or 0x8000.
- R10: A register write sets the live flag and its copy to (accumulator clamped OR half saturated) and ORs that value into the sticky flag. With destination code 0, all three flags are unchanged.
- R11: While valid_i is low, no accumulator, result or flag changes.
- R12: Operand signedness depends on the mode. Mode 1 is unsigned fractional (rounded half), 2 unsigned integer, 3 signed integer, 4 unsigned fractional (truncated half), 5 signed a by unsigned b, and codes 6 and 7 behave as mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Perform an operation this cycle |
| acc_sel_i | input | 1 | Accumulator select (0 = A0, 1 = A1) |
| op_i | input | 2 | Assign / add / subtract code |
| mode_i | input | 3 | Arithmetic mode |
| opa_i | input | 16 | Operand a |
| opb_i | input | 16 | Operand b |
| dst_i | input | 2 | Destination register write kind |
| reg_in_i | input | 32 | Current destination register value |
| acc0_o | output | 40 | Accumulator A0 |
| acc1_o | output | 40 | Accumulator A1 |
| reg_out_o | output | 32 | Last written register value |
| ovf0_o | output | 1 | A0 live overflow |
| ovf0_sticky_o | output | 1 | A0 sticky overflow |
| ovf1_o | output | 1 | A1 live overflow |
| ovf1_sticky_o | output | 1 | A1 sticky overflow |
| rovf_o | output | 1 | Register result overflow |
| rovf_copy_o | output | 1 | Copy of register result overflow |
| rovf_sticky_o | output | 1 | Sticky register result overflow |

## Verification
The bench builds the unit with its default 16-bit operands and 8 guard bits. At these sizes, every overflow boundary can be reached in one or two operations: the most-negative square, the signed and unsigned clamp edges, and the rounding carry out of the top half. A behavioural model over 64-bit integers runs next to the unit and is compared after every edge. Directed sequences hit each boundary, and a few thousand operations with biased random operands, modes and destinations cover the rest.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [2:0] {
    MODE_SFRAC       = 3'd0,
    MODE_UFRAC_RND   = 3'd1,
    MODE_UINT        = 3'd2,
    MODE_SINT        = 3'd3,
    MODE_UFRAC_TRUNC = 3'd4,
    MODE_MIXED       = 3'd5,
    MODE_ALT6        = 3'd6,
    MODE_ALT7        = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_ADD2 = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_FULL = 2'd1,
    DST_HIGH = 2'd2,
    DST_LOW  = 2'd3
  } dst_e;

  function automatic logic mode_unsigned(mode_e m);
    return (m == MODE_UFRAC_RND) || (m == MODE_UINT) || (m == MODE_UFRAC_TRUNC);
  endfunction
endpackage

// File: rtl/smac_product.sv
module smac_product import smac_pkg::*; #(
  parameter int OPW = 16
) (
  input  logic [OPW-1:0]          a_i,
  input  logic [OPW-1:0]          b_i,
  input  mode_e                   mode_i,
  output logic signed [2*OPW+1:0] prod_o,
  output logic                    sat_o
);
  localparam int RW = 2 * OPW;
  localparam int PW = RW + 2;
  localparam logic [OPW-1:0] MOST_NEG = {1'b1, {(OPW-1){1'b0}}};
  localparam logic signed [PW-1:0] FRAC_MAX = {{(PW-RW+1){1'b0}}, {(RW-1){1'b1}}};

  logic                 a_sgn, b_sgn;
  logic signed [PW-1:0] a_x, b_x, raw;

  always_comb begin
    a_sgn  = (mode_i == MODE_SFRAC) || (mode_i == MODE_SINT) || (mode_i == MODE_MIXED);
    b_sgn  = (mode_i == MODE_SFRAC) || (mode_i == MODE_SINT);
    a_x    = PW'($signed({a_sgn & a_i[OPW-1], a_i}));
    b_x    = PW'($signed({b_sgn & b_i[OPW-1], b_i}));
    raw    = a_x * b_x;
    prod_o = raw;
    sat_o  = 1'b0;
    if (mode_i == MODE_SFRAC) begin
      if ((a_i == MOST_NEG) && (b_i == MOST_NEG)) begin
        prod_o = FRAC_MAX;
        sat_o  = 1'b1;
      end else begin
        prod_o = raw <<< 1;
      end
    end
  end
endmodule

// File: rtl/smac_accum.sv
module smac_accum import smac_pkg::*; #(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic [2*OPW+GUARD-1:0]  old_i,
  input  logic signed [2*OPW+1:0] prod_i,
  input  op_e                     op_i,
  input  logic                    uns_i,
  output logic [2*OPW+GUARD-1:0]  new_o,
  output logic                    sat_o
);
  localparam int RW   = 2 * OPW;
  localparam int ACCW = RW + GUARD;
  localparam int SW   = ACCW + 2;
  localparam logic signed [SW-1:0] S_HI = {{(SW-RW+1){1'b0}}, {(RW-1){1'b1}}};
  localparam logic signed [SW-1:0] S_LO = {{(SW-RW+1){1'b1}}, {(RW-1){1'b0}}};
  localparam logic signed [SW-1:0] U_HI = {{(SW-RW){1'b0}}, {RW{1'b1}}};

  logic signed [SW-1:0] base, addend, sum, hi, lo;

  always_comb begin
    base   = (op_i == OP_SET) ? '0 : SW'($signed(old_i));
    addend = SW'(prod_i);
    sum    = (op_i == OP_SUB) ? (base - addend) : (base + addend);
    hi     = uns_i ? U_HI : S_HI;
    lo     = uns_i ? '0 : S_LO;
    new_o  = sum[ACCW-1:0];
    sat_o  = 1'b0;
    if (sum > hi) begin
      new_o = hi[ACCW-1:0];
      sat_o = 1'b1;
    end else if (sum < lo) begin
      new_o = lo[ACCW-1:0];
      sat_o = 1'b1;
    end
  end
endmodule

// File: rtl/smac_extract.sv
module smac_extract import smac_pkg::*; #(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic [2*OPW+GUARD-1:0] acc_i,
  input  mode_e                  mode_i,
  input  dst_e                   dst_i,
  input  logic [2*OPW-1:0]       reg_in_i,
  output logic [2*OPW-1:0]       reg_o,
  output logic                   sat_o
);
  localparam int RW   = 2 * OPW;
  localparam int ACCW = RW + GUARD;
  localparam int XW   = ACCW + 1;
  localparam logic signed [XW-1:0] RND    = {{(XW-OPW){1'b0}}, 1'b1, {(OPW-1){1'b0}}};
  localparam logic signed [XW-1:0] UFULL  = {{(XW-RW){1'b0}}, {RW{1'b1}}};
  localparam logic signed [XW-1:0] HU_MAX = {{(XW-OPW){1'b0}}, {OPW{1'b1}}};
  localparam logic signed [XW-1:0] HS_MAX = {{(XW-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
  localparam logic signed [XW-1:0] HS_MIN = {{(XW-OPW+1){1'b1}}, {(OPW-1){1'b0}}};

  logic signed [XW-1:0] val, rnd;
  logic [OPW-1:0]       half;
  logic                 hsat;

  always_comb begin
    val  = XW'($signed(acc_i));
    rnd  = val + RND;
    half = acc_i[RW-1:OPW];
    hsat = 1'b0;
    case (mode_i)
      MODE_UFRAC_RND: begin
        if (rnd > UFULL) begin half = '1; hsat = 1'b1; end
        else half = rnd[RW-1:OPW];
      end
      MODE_UINT: begin
        if (val > HU_MAX) begin half = '1; hsat = 1'b1; end
        else if (val[XW-1]) begin half = '0; hsat = 1'b1; end
        else half = val[OPW-1:0];
      end
      MODE_SINT, MODE_MIXED: begin
        if (val > HS_MAX) begin half = {1'b0, {(OPW-1){1'b1}}}; hsat = 1'b1; end
        else if (val < HS_MIN) begin half = {1'b1, {(OPW-1){1'b0}}}; hsat = 1'b1; end
        else half = val[OPW-1:0];
      end
      default: ;
    endcase

    reg_o = reg_in_i;
    sat_o = 1'b0;
    case (dst_i)
      DST_FULL: reg_o = acc_i[RW-1:0];
      DST_HIGH: begin reg_o = {half, reg_in_i[OPW-1:0]}; sat_o = hsat; end
      DST_LOW:  begin reg_o = {reg_in_i[RW-1:OPW], half}; sat_o = hsat; end
      default: ;
    endcase
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit import smac_pkg::*; #(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic                   acc_sel_i,
  input  logic [1:0]             op_i,
  input  logic [2:0]             mode_i,
  input  logic [OPW-1:0]         opa_i,
  input  logic [OPW-1:0]         opb_i,
  input  logic [1:0]             dst_i,
  input  logic [2*OPW-1:0]       reg_in_i,
  output logic [2*OPW+GUARD-1:0] acc0_o,
  output logic [2*OPW+GUARD-1:0] acc1_o,
  output logic [2*OPW-1:0]       reg_out_o,
  output logic                   ovf0_o,
  output logic                   ovf0_sticky_o,
  output logic                   ovf1_o,
  output logic                   ovf1_sticky_o,
  output logic                   rovf_o,
  output logic                   rovf_copy_o,
  output logic                   rovf_sticky_o
);
  localparam int RW    = 2 * OPW;
  localparam int ACCW  = RW + GUARD;
  localparam int PW    = RW + 2;
  localparam int NACC  = 2;
  localparam logic [OPW-1:0] MOST_NEG = {1'b1, {(OPW-1){1'b0}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  mode_e mode_c;
  op_e   op_c;
  dst_e  dst_c;
  logic  uns;
  always_comb begin
    mode_c = mode_e'(mode_i);
    if ((mode_c == MODE_ALT6) || (mode_c == MODE_ALT7)) mode_c = MODE_SINT;
    op_c  = op_e'(op_i);
    dst_c = dst_e'(dst_i);
    uns   = mode_unsigned(mode_c);
  end

  logic [ACCW-1:0] acc_q [NACC];
  logic [ACCW-1:0] acc_d [NACC];
  logic            ov_q  [NACC];
  logic            ov_d  [NACC];
  logic            ovs_q [NACC];
  logic            ovs_d [NACC];
  logic [RW-1:0]   reg_q, reg_d;
  logic            rv_q, rv_d, rvc_q, rvc_d, rvs_q, rvs_d;

  logic signed [PW-1:0] prod;
  logic                 psat, asat, esat;
  logic [ACCW-1:0]      acc_new;
  logic [RW-1:0]        ext_val;

  smac_product #(.OPW(OPW)) u_prod (
    .a_i(opa_i), .b_i(opb_i), .mode_i(mode_c), .prod_o(prod), .sat_o(psat)
  );

  smac_accum #(.OPW(OPW), .GUARD(GUARD)) u_acc (
    .old_i(acc_q[acc_sel_i]), .prod_i(prod), .op_i(op_c), .uns_i(uns),
    .new_o(acc_new), .sat_o(asat)
  );

  smac_extract #(.OPW(OPW), .GUARD(GUARD)) u_ext (
    .acc_i(acc_new), .mode_i(mode_c), .dst_i(dst_c), .reg_in_i(reg_in_i),
    .reg_o(ext_val), .sat_o(esat)
  );

  always_comb begin
    acc_d = acc_q;
    ov_d  = ov_q;
    ovs_d = ovs_q;
    reg_d = reg_q;
    rv_d  = rv_q;
    rvc_d = rvc_q;
    rvs_d = rvs_q;
    acc_d[acc_sel_i] = acc_new;
    ov_d[acc_sel_i]  = psat | asat;
    ovs_d[acc_sel_i] = ovs_q[acc_sel_i] | psat | asat;
    if (dst_c != DST_NONE) begin
      reg_d = ext_val;
      rv_d  = asat | esat;
      rvc_d = asat | esat;
      rvs_d = rvs_q | asat | esat;
    end
  end

  for (genvar g = 0; g < NACC; g++) begin : g_acc
    logic [ACCW-1:0] a_r;
    logic            o_r, s_r;
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        a_r <= '0;
        o_r <= 1'b0;
        s_r <= 1'b0;
      end else if (valid_i) begin
        a_r <= acc_d[g];
        o_r <= ov_d[g];
        s_r <= ovs_d[g];
      end
    end
    assign acc_q[g] = a_r;
    assign ov_q[g]  = o_r;
    assign ovs_q[g] = s_r;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      reg_q <= '0;
      rv_q  <= 1'b0;
      rvc_q <= 1'b0;
      rvs_q <= 1'b0;
    end else if (valid_i) begin
      reg_q <= reg_d;
      rv_q  <= rv_d;
      rvc_q <= rvc_d;
      rvs_q <= rvs_d;
    end
  end

  assign acc0_o        = acc_q[0];
  assign acc1_o        = acc_q[1];
  assign reg_out_o     = reg_q;
  assign ovf0_o        = ov_q[0];
  assign ovf0_sticky_o = ovs_q[0];
  assign ovf1_o        = ov_q[1];
  assign ovf1_sticky_o = ovs_q[1];
  assign rovf_o        = rv_q;
  assign rovf_copy_o   = rvc_q;
  assign rovf_sticky_o = rvs_q;

  // R2
  most_neg_square_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_i && !acc_sel_i && (mode_i == 3'd0) && (opa_i == MOST_NEG) && (opb_i == MOST_NEG))
      |=> (ov_q[0] && ovs_q[0]));

  // R3
  signed_clamp_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_i && !acc_sel_i && !uns)
      |=> ((acc_q[0][ACCW-1:RW-1] == '0) || (acc_q[0][ACCW-1:RW-1] == '1)));

  // R4
  unsigned_clamp_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_i && acc_sel_i && uns) |=> (acc_q[1][ACCW-1:RW] == '0));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ovs_q[0] && ovs_q[1]) |=> (ovs_q[0] && ovs_q[1]));

  // R6
  other_acc_flags_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_i && acc_sel_i) |=> ($stable(ov_q[0]) && $stable(ovs_q[0]) && $stable(acc_q[0])));

  // R10
  no_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (valid_i && (dst_i == 2'd0)) |=> ($stable(rv_q) && $stable(rvc_q) && $stable(reg_q)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !valid_i |=> ($stable(acc_q[0]) && $stable(acc_q[1]) && $stable(reg_q) && $stable(rvs_q)));
endmodule

// File: tb/sat_mac_unit_test.sv
module sat_mac_unit_test;
  localparam int OPW   = 16;
  localparam int GUARD = 8;
  localparam longint M40 = 64'h0000_00FF_FFFF_FFFF;
  localparam longint M32 = 64'h0000_0000_FFFF_FFFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, valid, sel;
  logic [1:0]  op, dst;
  logic [2:0]  mode;
  logic [15:0] a, b;
  logic [31:0] rin;
  logic [39:0] acc0, acc1;
  logic [31:0] rout;
  logic        ov0, ov0s, ov1, ov1s, rv, rvc, rvs;

  sat_mac_unit #(.OPW(OPW), .GUARD(GUARD)) uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .acc_sel_i(sel), .op_i(op),
    .mode_i(mode), .opa_i(a), .opb_i(b), .dst_i(dst), .reg_in_i(rin),
    .acc0_o(acc0), .acc1_o(acc1), .reg_out_o(rout),
    .ovf0_o(ov0), .ovf0_sticky_o(ov0s), .ovf1_o(ov1), .ovf1_sticky_o(ov1s),
    .rovf_o(rv), .rovf_copy_o(rvc), .rovf_sticky_o(rvs)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  longint m_acc [2];
  bit     m_ov  [2];
  bit     m_ovs [2];
  longint m_reg;
  bit     m_v, m_vc, m_vs;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "acc0", {24'd0, acc0}, m_acc[0] & M40);
    chk(tag, "acc1", {24'd0, acc1}, m_acc[1] & M40);
    chk(tag, "reg",  {32'd0, rout}, m_reg & M32);
    chk(tag, "ovf0", {63'd0, ov0},  {63'd0, m_ov[0]});
    chk(tag, "ovf0s",{63'd0, ov0s}, {63'd0, m_ovs[0]});
    chk(tag, "ovf1", {63'd0, ov1},  {63'd0, m_ov[1]});
    chk(tag, "ovf1s",{63'd0, ov1s}, {63'd0, m_ovs[1]});
    chk(tag, "rovf", {63'd0, rv},   {63'd0, m_v});
    chk(tag, "rovfc",{63'd0, rvc},  {63'd0, m_vc});
    chk(tag, "rovfs",{63'd0, rvs},  {63'd0, m_vs});
  endtask

  // behavioural reference for one accepted operation
  task automatic model_step(input bit s, input int o, input int md, input logic [15:0] aa,
                            input logic [15:0] bb, input int d, input logic [31:0] ri);
    int     m;
    bit     as, bs, uns, psat, asat, esat;
    longint av, bv, p, base, r, hi, lo, h, rr;
    m   = (md >= 6) ? 3 : md;
    as  = (m == 0) || (m == 3) || (m == 5);
    bs  = (m == 0) || (m == 3);
    uns = (m == 1) || (m == 2) || (m == 4);
    av  = as ? longint'($signed(aa)) : longint'(aa);
    bv  = bs ? longint'($signed(bb)) : longint'(bb);
    psat = 0;
    if (m == 0) begin
      if (aa == 16'h8000 && bb == 16'h8000) begin p = 64'h7FFF_FFFF; psat = 1; end
      else p = av * bv * 2;
    end else p = av * bv;
    base = (o == 0) ? 0 : m_acc[s];
    r    = (o == 2) ? base - p : base + p;
    hi   = uns ? 64'hFFFF_FFFF : 64'h7FFF_FFFF;
    lo   = uns ? 0 : -64'sh8000_0000;
    asat = 0;
    if (r > hi) begin r = hi; asat = 1; end
    else if (r < lo) begin r = lo; asat = 1; end
    m_acc[s] = r;
    m_ov[s]  = psat | asat;
    m_ovs[s] = m_ovs[s] | psat | asat;
    if (d != 0) begin
      esat = 0;
      h = (r >>> 16) & 64'hFFFF;
      if (m == 1) begin
        rr = r + 32768;
        if (rr > 64'hFFFF_FFFF) begin h = 64'hFFFF; esat = 1; end
        else h = (rr >> 16) & 64'hFFFF;
      end else if (m == 2) begin
        if (r > 65535) begin h = 64'hFFFF; esat = 1; end
        else if (r < 0) begin h = 0; esat = 1; end
        else h = r;
      end else if (m == 3 || m == 5) begin
        if (r > 32767) begin h = 64'h7FFF; esat = 1; end
        else if (r < -32768) begin h = 64'h8000; esat = 1; end
        else h = r & 64'hFFFF;
      end
      if (d == 1) begin m_reg = r & M32; esat = 0; end
      else if (d == 2) m_reg = (h << 16) | (longint'(ri) & 64'hFFFF);
      else m_reg = (longint'(ri) & 64'hFFFF_0000) | h;
      m_v  = asat | esat;
      m_vc = asat | esat;
      m_vs = m_vs | asat | esat;
    end
  endtask

  task automatic op_step(input bit s, input int o, input int md, input logic [15:0] aa,
                         input logic [15:0] bb, input int d, input logic [31:0] ri, input string tag);
    @(negedge clk);
    valid = 1'b1; sel = s; op = o[1:0]; mode = md[2:0]; a = aa; b = bb; dst = d[1:0]; rin = ri;
    model_step(s, o, md, aa, bb, d, ri);
    @(posedge clk); #1;
    compare_all(tag);
  endtask

  task automatic idle_step(input string tag);
    @(negedge clk);
    valid = 1'b0; sel = $urandom; op = $urandom; mode = $urandom;
    a = $urandom; b = $urandom; dst = $urandom; rin = $urandom;
    @(posedge clk); #1;
    compare_all(tag);
  endtask

  function automatic logic [15:0] pick16();
    int k;
    k = $urandom % 8;
    case (k)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'hFFFF;
      3: return 16'h0000;
      4: return 16'h0001;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_acc[i] = 0; m_ov[i] = 0; m_ovs[i] = 0; end
    m_reg = 0; m_v = 0; m_vc = 0; m_vs = 0;
    rst_n = 1'b0; valid = 1'b0; sel = 1'b0; op = 2'd0; mode = 3'd0;
    a = '0; b = '0; dst = 2'd0; rin = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    compare_all("R1 reset");

    // R7 R8: assign in unsigned integer mode, full register write
    op_step(0, 0, 2, 16'h4000, 16'h4000, 1, 32'h0, "R7 assign");
    chk("R8", "reg full", {32'd0, rout}, 64'h1000_0000);
    // R2: most-negative square in signed fractional mode
    op_step(0, 2, 0, 16'h8000, 16'h8000, 0, 32'h0, "R2 sub");
    chk("R2", "acc0", {24'd0, acc0}, 64'hFF_9000_0001);
    chk("R2", "ovf0", {63'd0, ov0 & ov0s}, 64'd1);
    // R6: A1 operation leaves A0 flags
    op_step(1, 1, 0, 16'h0100, 16'h0100, 0, 32'h0, "R6 other acc");
    chk("R6", "acc1", {24'd0, acc1}, 64'h2_0000);
    chk("R6", "ovf0 kept", {63'd0, ov0}, 64'd1);
    // R5: live flag clears, sticky stays
    op_step(0, 1, 0, 16'h0100, 16'h0100, 0, 32'h0, "R5 live clears");
    chk("R5", "flags", {62'd0, ov0, ov0s}, 64'd1);
    chk("R5", "acc0", {24'd0, acc0}, 64'hFF_9002_0001);
    // R3: positive then negative clamp
    op_step(1, 0, 0, 16'h7FFF, 16'h7FFF, 0, 32'h0, "R3 load");
    op_step(1, 1, 0, 16'h7FFF, 16'h7FFF, 0, 32'h0, "R3 pos");
    chk("R3", "acc1 pos", {24'd0, acc1}, 64'h00_7FFF_FFFF);
    op_step(1, 0, 0, 16'h8000, 16'h7FFF, 0, 32'h0, "R3 load neg");
    op_step(1, 3, 0, 16'h8000, 16'h7FFF, 1, 32'h0, "R3 neg");
    chk("R3", "acc1 neg", {24'd0, acc1}, 64'hFF_8000_0000);
    chk("R10", "rovf set", {61'd0, rv, rvc, rvs}, 64'd7);
    // R10: no write keeps flags; clean full write clears live, keeps sticky
    op_step(1, 1, 0, 16'h0001, 16'h0001, 0, 32'h0, "R10 none");
    chk("R10", "rovf kept", {63'd0, rv}, 64'd1);
    op_step(1, 0, 0, 16'h0001, 16'h0001, 1, 32'h0, "R10 clean");
    chk("R10", "rovf cleared", {61'd0, rv, rvc, rvs}, 64'd1);
    // R4: unsigned clamp below zero
    op_step(0, 0, 1, 16'h0001, 16'h0001, 0, 32'h0, "R4 load");
    op_step(0, 2, 1, 16'h0002, 16'h0001, 1, 32'h0, "R4 under");
    chk("R4", "acc0", {24'd0, acc0}, 64'h0);
    chk("R4", "flags", {62'd0, ov0, rv}, 64'd3);
    // R9 R8: half extraction variants
    op_step(0, 0, 3, 16'h8000, 16'h7FFF, 2, 32'h1234_5678, "R9 sint high");
    chk("R9", "reg", {32'd0, rout}, 64'h8000_5678);
    chk("R9", "acc0", {24'd0, acc0}, 64'hFF_C000_8000);
    op_step(0, 0, 2, 16'h0100, 16'h0100, 3, 32'hABCD_0000, "R9 uint low");
    chk("R9", "reg", {32'd0, rout}, 64'hABCD_FFFF);
    op_step(0, 0, 1, 16'h8000, 16'h0001, 2, 32'h0000_AAAA, "R9 round");
    chk("R9", "reg round", {32'd0, rout}, 64'h0001_AAAA);
    chk("R9", "rovf", {63'd0, rv}, 64'd0);
    op_step(0, 0, 4, 16'h8000, 16'h0001, 2, 32'h0000_AAAA, "R9 trunc");
    chk("R9", "reg trunc", {32'd0, rout}, 64'h0000_AAAA);
    // R11: idle cycles change nothing
    for (int i = 0; i < 4; i++) idle_step("R11 idle");
    chk("R11", "acc0", {24'd0, acc0}, 64'h8000);
    // R12: mixed signedness and alias codes
    op_step(0, 0, 5, 16'hFFFF, 16'hFFFF, 3, 32'h0, "R12 mixed");
    chk("R12", "acc0", {24'd0, acc0}, 64'hFF_FFFF_0001);
    chk("R12", "reg", {32'd0, rout}, 64'h0000_8000);
    op_step(0, 0, 6, 16'hFFFF, 16'hFFFF, 1, 32'h0, "R12 alias6");
    chk("R12", "reg", {32'd0, rout}, 64'h1);
    op_step(1, 0, 7, 16'h8000, 16'h8000, 1, 32'h0, "R12 alias7");
    chk("R12", "acc1", {24'd0, acc1}, 64'h4000_0000);

    // mixed random traffic, all outputs compared every edge
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) idle_step("R11 rand");
      else op_step(1'($urandom), $urandom % 4, $urandom % 8, pick16(), pick16(),
                   $urandom % 4, 32'($urandom), "R5 R9 rand");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule